// File: doc/BRIEF.md
# Serial Receiver with Error Flags and Receive Queue

This block recovers bytes from an asynchronous serial line. A clock enable running at eight times the bit rate drives an oversampling frame recovery engine. The engine accepts a start bit only when the line is still low at mid-bit. It collects seven or eight data bits, least significant bit first, and checks an optional parity bit in one of four modes. It then judges the stop bit. Each recovered byte goes into a receive queue together with its own parity, framing and break flags. The head entry of the queue is always visible, and a single-cycle pop strobe moves on to the next entry.

The line input passes through a synchronizer before sampling. A loopback select routes the local transmit line into the receiver in place of the pin. The queue fill count is reported on a 7-bit output. A data-available output rises once the fill reaches a programmable 5-bit trigger. When flow control is enabled, a ready-to-send output drops as soon as the fill reaches a separate programmable 5-bit level. A sticky overflow flag records any byte lost to a full queue. A flush strobe empties the queue and clears that flag.

Top module: `serial_rx_unit`

## Requirements
- R1: After a synchronous reset, `fill` is 0, `avail` is 0, `ovf` is 0 and `rts` is 1.
- R2: A frame has a low start bit, data bits sent least significant bit first, and a high stop bit. Such a frame appends its byte to the queue and raises `fill` by one. `rd_data` shows the oldest entry. A `pop` pulse removes that entry, and `rd_data` then shows the next one.
- R3: With `data8` = 0, seven data bits are taken and the stored byte has bit 7 equal to 0. With `data8` = 1, eight data bits are taken.
- R4: With `par_en` = 1, one parity bit follows the data. `par_mode` 0 expects odd parity, 1 expects even, 2 expects a constant 0 and 3 expects a constant 1. A mismatch sets `rd_par_err` for that entry only.
- R5: A stop bit sampled low after data that is not all zero stores the byte with `rd_frm_err` = 1 and `rd_brk` = 0.
- R6: A frame whose data bits (and parity bit, when enabled) are all zero and whose stop bit is low stores one zero byte with `rd_brk` = 1 and `rd_frm_err` = 0. The receiver then waits for the line to return high, so a long low period yields exactly one entry.
- R7: A low pulse that has ended by the mid-bit sample, four ticks after the low is first seen, is rejected and stores nothing.
- R8: A byte that completes while `fill` equals DEPTH is discarded, `fill` stays at DEPTH and `ovf` is set. `ovf` then stays set until a flush.
- R9: A `flush` pulse makes `fill` 0 and clears `ovf` on the next cycle.
- R10: `avail` is 1 exactly when `fill` is nonzero and `fill` is at least `trig_lvl`.
- R11: With `flow_en` = 0, `rts` is 1. With `flow_en` = 1, `rts` is 0 exactly when `fill` is at least `rts_lvl`.
- R12: With `lb_en` = 1, frames are taken from `lb_txd`, and activity on `rx_pin` has no effect.
- R13: A `pop` while the queue is empty leaves `fill` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Enable at eight times the bit rate |
| rx_pin | input | 1 | Serial line from the pin |
| lb_txd | input | 1 | Local transmit line used in loopback |
| lb_en | input | 1 | 1 selects `lb_txd` as the receive source |
| data8 | input | 1 | 1 = eight data bits, 0 = seven |
| par_en | input | 1 | Parity bit present |
| par_mode | input | 2 | 0 odd, 1 even, 2 constant 0, 3 constant 1 |
| flow_en | input | 1 | Enables automatic `rts` control |
| trig_lvl | input | 5 | Fill at which `avail` rises |
| rts_lvl | input | 5 | Fill at which `rts` drops |
| flush | input | 1 | Empties the queue and clears `ovf` |
| pop | input | 1 | Removes the head entry |
| rd_data | output | 8 | Head byte (valid while `fill` is nonzero) |
| rd_par_err | output | 1 | Head entry had a parity mismatch |
| rd_frm_err | output | 1 | Head entry had a low stop bit |
| rd_brk | output | 1 | Head entry was a break |
| fill | output | 7 | Number of queued entries |
| ovf | output | 1 | Sticky lost-byte flag |
| avail | output | 1 | Fill has reached the trigger |
| rts | output | 1 | Ready to send (1 = accept more data) |

## Verification
The assertions check, on every cycle, the relations among the queue's visible state. `fill` never passes DEPTH, and without a flush it moves by at most one per cycle. A flush empties the queue and clears `ovf`, and `ovf` stays set until a flush. `avail` and `rts` agree with `fill` and their thresholds. A pop on an empty queue does not drive the fill down. Only the bench's scenarios can show the line-level behaviour: bit order, seven- and eight-bit framing, the four parity modes, framing errors, single-entry breaks, rejection of start glitches and loopback source selection. For these the bench drives real frames and compares every output against a behavioural model on each clock.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    PM_ODD   = 2'd0,
    PM_EVEN  = 2'd1,
    PM_SPACE = 2'd2,
    PM_MARK  = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAITHI
  } rx_state_e;

  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       perr;
    logic [7:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  // Parity bit value a sender would attach to the collected data bits.
  function automatic logic want_parity(input logic [7:0] d, input par_mode_e m);
    logic x;
    x = ^d;
    case (m)
      PM_ODD:   want_parity = ~x;
      PM_EVEN:  want_parity = x;
      PM_SPACE: want_parity = 1'b0;
      default:  want_parity = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic lb_txd,
  input  logic lb_en,
  output logic line_s
);

  logic              src;
  logic [STAGES-1:0] chain;

  assign src = lb_en ? lb_txd : pin;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b1;
        else     chain[g] <= src;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b1;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign line_s = chain[STAGES-1];

endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import serial_rx_pkg::*;
#(
  parameter int OVS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       line_s,
  input  logic       data8,
  input  logic       par_en,
  input  logic [1:0] par_mode,
  output logic       push,
  output rx_entry_t  entry
);

  localparam int             PW     = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [PW-1:0]  PH_MID = PW'(OVS / 2 - 1);
  localparam logic [PW-1:0]  PH_END = PW'(OVS - 1);

  rx_state_e     st;
  logic [PW-1:0] ph;
  logic [2:0]    idx;
  logic [7:0]    sh;
  logic          pbit;

  logic [2:0] last_idx;
  logic       at_mid, at_end, exp_p, all_zero;

  assign last_idx = data8 ? 3'd7 : 3'd6;
  assign at_mid   = (ph == PH_MID);
  assign at_end   = (ph == PH_END);
  assign exp_p    = want_parity(sh, par_mode_e'(par_mode));
  assign all_zero = (sh == 8'h00) && !(par_en && pbit);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      ph    <= '0;
      idx   <= '0;
      sh    <= '0;
      pbit  <= 1'b0;
      push  <= 1'b0;
      entry <= '0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        case (st)
          ST_IDLE: begin
            if (!line_s) begin
              st <= ST_START;
              ph <= '0;
            end
          end
          ST_START: begin
            if (at_mid) begin
              ph <= '0;
              if (!line_s) begin
                st   <= ST_DATA;
                idx  <= '0;
                sh   <= '0;
                pbit <= 1'b0;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              ph <= ph + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_end) begin
              ph      <= '0;
              sh[idx] <= line_s;
              if (idx == last_idx) st <= par_en ? ST_PAR : ST_STOP;
              else                 idx <= idx + 1'b1;
            end else begin
              ph <= ph + 1'b1;
            end
          end
          ST_PAR: begin
            if (at_end) begin
              ph   <= '0;
              pbit <= line_s;
              st   <= ST_STOP;
            end else begin
              ph <= ph + 1'b1;
            end
          end
          ST_STOP: begin
            if (at_end) begin
              ph         <= '0;
              push       <= 1'b1;
              entry.data <= sh;
              entry.perr <= par_en && (pbit != exp_p);
              entry.frm  <= !line_s && !all_zero;
              entry.brk  <= !line_s && all_zero;
              st         <= line_s ? ST_IDLE : ST_WAITHI;
            end else begin
              ph <= ph + 1'b1;
            end
          end
          ST_WAITHI: begin
            if (line_s) st <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 11,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr,
  input  logic [W-1:0]     wdata,
  input  logic             rd,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt,
  output logic             ovf
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, empty, do_wr, do_rd;

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);
  assign do_wr = wr && !full && !flush;
  assign do_rd = rd && !empty && !flush;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
  end

  assign rdata = mem[rp];

  always_comb begin
    count_nxt = count;
    if (flush) count_nxt = '0;
    else if (do_wr && !do_rd) count_nxt = count + 1'b1;
    else if (!do_wr && do_rd) count_nxt = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      count <= count_nxt;
      if (flush) begin
        wp  <= '0;
        rp  <= '0;
        ovf <= 1'b0;
      end else begin
        if (do_wr) wp <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
        if (do_rd) rp <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
        if (wr && full) ovf <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import serial_rx_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int OVS         = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 7,
  parameter int LVL_W       = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             rx_pin,
  input  logic             lb_txd,
  input  logic             lb_en,
  input  logic             data8,
  input  logic             par_en,
  input  logic [1:0]       par_mode,
  input  logic             flow_en,
  input  logic [LVL_W-1:0] trig_lvl,
  input  logic [LVL_W-1:0] rts_lvl,
  input  logic             flush,
  input  logic             pop,
  output logic [7:0]       rd_data,
  output logic             rd_par_err,
  output logic             rd_frm_err,
  output logic             rd_brk,
  output logic [CNT_W-1:0] fill,
  output logic             ovf,
  output logic             avail,
  output logic             rts
);

  logic                line_s;
  logic                push;
  rx_entry_t           new_entry;
  rx_entry_t           head;
  logic [ENTRY_W-1:0]  head_v;
  logic [CNT_W-1:0]    count_nxt;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin    (rx_pin),
    .lb_txd (lb_txd),
    .lb_en  (lb_en),
    .line_s (line_s)
  );

  rx_framer #(.OVS(OVS)) u_framer (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .line_s   (line_s),
    .data8    (data8),
    .par_en   (par_en),
    .par_mode (par_mode),
    .push     (push),
    .entry    (new_entry)
  );

  rx_fifo #(.DEPTH(DEPTH), .W(ENTRY_W), .CNT_W(CNT_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .wr        (push),
    .wdata     (new_entry),
    .rd        (pop),
    .rdata     (head_v),
    .count     (fill),
    .count_nxt (count_nxt),
    .ovf       (ovf)
  );

  assign head       = rx_entry_t'(head_v);
  assign rd_data    = head.data;
  assign rd_par_err = head.perr;
  assign rd_frm_err = head.frm;
  assign rd_brk     = head.brk;

  always_ff @(posedge clk) begin
    if (rst) begin
      avail <= 1'b0;
      rts   <= 1'b1;
    end else begin
      avail <= (count_nxt != '0) && (count_nxt >= CNT_W'(trig_lvl));
      rts   <= !flow_en || (count_nxt < CNT_W'(rts_lvl));
    end
  end

endmodule

// File: rtl/serial_rx_unit_chk.sv
module serial_rx_unit_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             pop,
  input logic [CNT_W-1:0] fill,
  input logic             ovf,
  input logic             avail,
  input logic             rts,
  input logic             flow_en,
  input logic [LVL_W-1:0] trig_lvl,
  input logic [LVL_W-1:0] rts_lvl
);

  p_fill_bound_r8: assert property (@(posedge clk) disable iff (rst)
    fill <= CNT_W'(DEPTH));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf && !flush) |=> ovf);

  p_fill_step_r2: assert property (@(posedge clk) disable iff (rst)
    !flush |=> (fill == $past(fill)) || (fill == $past(fill) + 1'b1) ||
               (fill == $past(fill) - 1'b1));

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fill == '0) && !ovf);

  p_avail_level_r10: assert property (@(posedge clk) disable iff (rst)
    $stable(trig_lvl) |-> (avail == ((fill != '0) && (fill >= CNT_W'(trig_lvl)))));

  p_rts_level_r11: assert property (@(posedge clk) disable iff (rst)
    ($stable(flow_en) && $stable(rts_lvl)) |->
      (rts == (!flow_en || (fill < CNT_W'(rts_lvl)))));

  p_pop_empty_r13: assert property (@(posedge clk) disable iff (rst)
    (fill == '0 && pop && !flush) |=> (fill <= 1));

endmodule

bind serial_rx_unit serial_rx_unit_chk #(
  .DEPTH (DEPTH),
  .CNT_W (CNT_W),
  .LVL_W (LVL_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .flush    (flush),
  .pop      (pop),
  .fill     (fill),
  .ovf      (ovf),
  .avail    (avail),
  .rts      (rts),
  .flow_en  (flow_en),
  .trig_lvl (trig_lvl),
  .rts_lvl  (rts_lvl)
);

// File: tb/serial_rx_unit_tb.sv
`timescale 1ns/1ps
module serial_rx_unit_tb;

  localparam int DEPTH = 64;
  localparam int CNT_W = 7;
  localparam int LVL_W = 5;
  localparam int BITCLK = 32; // 8 ticks of 4 clocks

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic rx_pin = 1'b1, lb_txd = 1'b1, lb_en = 1'b0;
  logic data8 = 1'b1, par_en = 1'b0, flow_en = 1'b0, flush = 1'b0, pop = 1'b0;
  logic [1:0] par_mode = 2'd0;
  logic [LVL_W-1:0] trig_lvl = 5'd16, rts_lvl = 5'd20;
  logic [7:0] rd_data;
  logic rd_par_err, rd_frm_err, rd_brk, ovf, avail, rts;
  logic [CNT_W-1:0] fill;

  int n_chk = 0, n_fail = 0, tc = 0;
  bit done = 0;

  serial_rx_unit #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .rx_pin(rx_pin), .lb_txd(lb_txd),
    .lb_en(lb_en), .data8(data8), .par_en(par_en), .par_mode(par_mode),
    .flow_en(flow_en), .trig_lvl(trig_lvl), .rts_lvl(rts_lvl), .flush(flush),
    .pop(pop), .rd_data(rd_data), .rd_par_err(rd_par_err),
    .rd_frm_err(rd_frm_err), .rd_brk(rd_brk), .fill(fill), .ovf(ovf),
    .avail(avail), .rts(rts)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (rst) begin tc <= 0; tick <= 1'b0; end
    else begin tick <= (tc == 3); tc <= (tc + 1) % 4; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit par_for(input logic [7:0] d, input int nb, input int mode);
    int ones = 0;
    for (int i = 0; i < nb; i++) ones += d[i];
    case (mode)
      0: return (ones % 2 == 0);
      1: return (ones % 2 == 1);
      2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [10:0] q[$];
  bit   ms1 = 1, ms2 = 1, m_push = 0, movf = 0, mavail = 0, mrts = 1;
  logic [10:0] m_ent;
  int   mst = 0, mph = 0, mbit = 0;
  logic [7:0] mdat;
  bit   mpar;

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); ms1 = 1; ms2 = 1; m_push = 0; movf = 0; mavail = 0; mrts = 1;
      mst = 0; mph = 0; mbit = 0; mdat = 0; mpar = 0; m_ent = 0;
    end else begin
      bit was_full;
      was_full = (q.size() == DEPTH);
      if (flush) begin
        q.delete(); movf = 0;
      end else begin
        if (m_push && was_full) movf = 1;
        if (pop && q.size() > 0) void'(q.pop_front());
        if (m_push && !was_full) q.push_back(m_ent);
      end
      mavail = (q.size() != 0) && (q.size() >= int'(trig_lvl));
      mrts   = !flow_en || (q.size() < int'(rts_lvl));
      m_push = 0;
      if (tick) begin
        case (mst)
          0: if (!ms2) begin mst = 1; mph = 0; end
          1: begin
               if (mph == 3) begin
                 mph = 0;
                 if (!ms2) begin mst = 2; mbit = 0; mdat = 0; mpar = 0; end
                 else mst = 0;
               end else mph++;
             end
          2: begin
               if (mph == 7) begin
                 mph = 0; mdat[mbit] = ms2; mbit++;
                 if (mbit == (data8 ? 8 : 7)) mst = par_en ? 3 : 4;
               end else mph++;
             end
          3: begin
               if (mph == 7) begin mph = 0; mpar = ms2; mst = 4; end else mph++;
             end
          4: begin
               if (mph == 7) begin
                 bit z;
                 mph = 0;
                 z = (mdat == 0) && !(par_en && mpar);
                 m_ent[7:0] = mdat;
                 m_ent[8]   = par_en && (mpar != par_for(mdat, data8 ? 8 : 7, par_mode));
                 m_ent[9]   = !ms2 && !z;
                 m_ent[10]  = !ms2 && z;
                 m_push = 1;
                 mst = ms2 ? 0 : 5;
               end else mph++;
             end
          default: if (ms2) mst = 0;
        endcase
      end
      ms2 = ms1;
      ms1 = lb_en ? lb_txd : rx_pin;
    end
  end

  // compare against the model on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 model fill", 32'(fill), 32'(q.size()));
      chk("R8 model ovf", 32'(ovf), 32'(movf));
      chk("R10 model avail", 32'(avail), 32'(mavail));
      chk("R11 model rts", 32'(rts), 32'(mrts));
      if (q.size() > 0)
        chk("R2 model head", 32'({rd_brk, rd_frm_err, rd_par_err, rd_data}), 32'(q[0]));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive_bit(input bit v, input bit via_lb);
    if (via_lb) lb_txd = v; else rx_pin = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit use_par,
                      input bit pb, input bit stopv, input bit via_lb);
    drive_bit(1'b0, via_lb);
    for (int i = 0; i < nb; i++) drive_bit(d[i], via_lb);
    if (use_par) drive_bit(pb, via_lb);
    drive_bit(stopv, via_lb);
    drive_bit(1'b1, via_lb);
  endtask

  task automatic do_pop();
    pop = 1'b1; @(negedge clk); pop = 1'b0; @(negedge clk);
  endtask

  task automatic do_flush();
    flush = 1'b1; @(negedge clk); flush = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 fill", 32'(fill), 0);
    chk("R1 avail", 32'(avail), 0);
    chk("R1 ovf", 32'(ovf), 0);
    chk("R1 rts", 32'(rts), 1);

    // R2 eight-bit frames, LSB first
    send(8'hA5, 8, 0, 0, 1, 0);
    send(8'h3C, 8, 0, 0, 1, 0);
    chk("R2 fill two", 32'(fill), 2);
    chk("R2 first byte", 32'(rd_data), 32'hA5);
    do_pop();
    chk("R2 second byte", 32'(rd_data), 32'h3C);
    do_pop();
    chk("R2 drained", 32'(fill), 0);

    // R13 pop on empty
    do_pop();
    chk("R13 empty pop", 32'(fill), 0);

    // R3 seven-bit frame
    data8 = 1'b0;
    send(8'hFF, 7, 0, 0, 1, 0);
    chk("R3 seven bit data", 32'(rd_data), 32'h7F);
    do_pop();
    data8 = 1'b1;

    // R4 parity modes
    par_en = 1'b1;
    for (int m = 0; m < 4; m++) begin
      bit good;
      par_mode = 2'(m);
      good = par_for(8'h5A, 8, m);
      send(8'h5A, 8, 1, good, 1, 0);
      send(8'h5A, 8, 1, !good, 1, 0);
      chk($sformatf("R4 mode %0d good parity", m), 32'(rd_par_err), 0);
      do_pop();
      chk($sformatf("R4 mode %0d bad parity", m), 32'(rd_par_err), 1);
      do_pop();
    end
    par_en = 1'b0;

    // R5 framing error
    send(8'h55, 8, 0, 0, 0, 0);
    chk("R5 frame flag", 32'(rd_frm_err), 1);
    chk("R5 not break", 32'(rd_brk), 0);
    chk("R5 data kept", 32'(rd_data), 32'h55);
    do_pop();

    // R6 break: long low period
    rx_pin = 1'b0;
    repeat (3 * 10 * BITCLK) @(negedge clk);
    rx_pin = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
    chk("R6 single entry", 32'(fill), 1);
    chk("R6 break flag", 32'(rd_brk), 1);
    chk("R6 no frame flag", 32'(rd_frm_err), 0);
    chk("R6 zero data", 32'(rd_data), 0);
    do_pop();

    // R7 start glitch
    rx_pin = 1'b0; repeat (2) @(negedge clk); rx_pin = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    chk("R7 glitch rejected", 32'(fill), 0);

    // R10 trigger level
    trig_lvl = 5'd3;
    send(8'h01, 8, 0, 0, 1, 0);
    send(8'h02, 8, 0, 0, 1, 0);
    chk("R10 below trigger", 32'(avail), 0);
    send(8'h03, 8, 0, 0, 1, 0);
    chk("R10 at trigger", 32'(avail), 1);
    do_pop();
    chk("R10 after pop", 32'(avail), 0);

    // R11 flow control
    rts_lvl = 5'd4;
    chk("R11 flow off", 32'(rts), 1);
    flow_en = 1'b1;
    repeat (2) @(negedge clk);
    send(8'h04, 8, 0, 0, 1, 0);
    chk("R11 below level", 32'(rts), 1);
    send(8'h05, 8, 0, 0, 1, 0);
    chk("R11 at level", 32'(rts), 0);
    flow_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 flow disabled", 32'(rts), 1);

    // R9 flush
    do_flush();
    chk("R9 flush fill", 32'(fill), 0);

    // R8 overflow
    trig_lvl = 5'd16; rts_lvl = 5'd20;
    for (int i = 0; i < DEPTH; i++) send(8'(i + 1), 8, 0, 0, 1, 0);
    chk("R8 full fill", 32'(fill), DEPTH);
    chk("R8 no ovf yet", 32'(ovf), 0);
    send(8'hEE, 8, 0, 0, 1, 0);
    chk("R8 fill held", 32'(fill), DEPTH);
    chk("R8 ovf set", 32'(ovf), 1);
    chk("R8 head kept", 32'(rd_data), 1);
    do_flush();
    chk("R9 ovf cleared", 32'(ovf), 0);
    chk("R9 fill cleared", 32'(fill), 0);

    // R12 loopback
    rx_pin = 1'b0;
    lb_en = 1'b1;
    repeat (4) @(negedge clk);
    send(8'h96, 8, 0, 0, 1, 1);
    chk("R12 loopback entry", 32'(fill), 1);
    chk("R12 loopback data", 32'(rd_data), 32'h96);
    rx_pin = 1'b1;
    send(8'h42, 8, 0, 0, 1, 0);
    chk("R12 pin ignored", 32'(fill), 1);
    lb_en = 1'b0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule